// File: doc/BRIEF.md
# Endian-Configurable Byte Memory with Word Port

This block is a small byte-organised storage array with a 32-bit load/store port in front of it. Each storage location holds one byte. A load or store names a byte address and an access size: one byte, two bytes or four bytes. The port splits a value into bytes and places them at consecutive addresses, or gathers them from there. A mode input selects the byte order. In big-endian order the most significant byte of a value sits at its lowest address. In little-endian order the least significant byte sits there. The same stored bytes can therefore be read under either convention.

An alignment check runs on every access. A four-byte access must start on a multiple of four. A two-byte access must start on an even address. A request that breaks these rules raises a flag, writes nothing and returns zero. Stores take effect on the rising clock edge. Loads are combinational from the current contents, so a load presented in the same cycle as a store to the same address still returns the old bytes. The mode input only affects how later accesses are interpreted. Bytes already stored are never moved.

Top module: `emem_port`

## Requirements
- R1: A synchronous active-high reset clears every byte location to 0x00. After reset, every load returns zero.
- R2: A little-endian four-byte store to aligned address A writes wdata[8k+7:8k] to address A+k for k = 0..3. Storing 0x87654321 at 0 leaves 21, 43, 65, 87 at addresses 0..3.
- R3: A big-endian four-byte store to aligned address A writes wdata[31-8k:24-8k] to address A+k. Storing 0x87654321 at 0 leaves 87, 65, 43, 21 at addresses 0..3.
- R4: A two-byte store to even address A changes only A and A+1. In little-endian order A receives wdata[7:0] and A+1 receives wdata[15:8]. In big-endian order A receives wdata[15:8] and A+1 receives wdata[7:0].
- R5: A one-byte store writes wdata[7:0] to address A in either mode and changes no other byte. wdata[31:8] is ignored.
- R6: A load gathers bytes with the same mapping as a store of that size and mode. One-byte and two-byte loads are zero-extended, so rdata[31:8] or rdata[31:16] reads 0.
- R7: The size input is encoded 2'b00 = one byte, 2'b01 = two bytes, 2'b10 = four bytes, and 2'b11 is reserved. misalign is 1 in these cases: a four-byte access with addr[1:0] != 0, a two-byte access with addr[0] = 1, or a reserved size. While misalign is 1, no byte changes even with wr_en = 1, and rdata is 0.
- R8: Changing big_endian never rearranges stored bytes. A four-byte value stored in one order and loaded in the other comes back byte-reversed.
- R9: A store commits on the rising edge while wr_en is 1. Before that edge, a load of the same address returns the previous contents. With wr_en at 0, no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the lowest byte of the access |
| size | input | 2 | Access size code (see R7) |
| wr_en | input | 1 | Store when 1, load only when 0 |
| wdata | input | 32 | Store value, right-justified for narrow sizes |
| big_endian | input | 1 | 1 selects big-endian byte order, 0 selects little-endian |
| rdata | output | 32 | Load value, zero-extended |
| misalign | output | 1 | Access breaks alignment rules or uses the reserved size |

## Verification
The embedded assertions check on every cycle that:
- a flagged access enables no byte lane and returns zero;
- narrow loads are zero-extended;
- each enabled lane's byte appears in storage after the edge;
- storage stays unchanged in any cycle without a lane write.

Only the bench scenarios can show that the byte order itself is right. These scenarios cover:
- the 0x87654321 layout in both modes;
- two-byte placement and single-byte isolation;
- reading old contents before a same-cycle store commits;
- reading a value back in the other mode, which shows that a mode change leaves stored bytes unmoved.

// File: rtl/emem_pkg.sv
package emem_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Per-lane routing: lane k covers address base+k and maps to word byte src.
    typedef struct packed {
        logic       active;
        logic [1:0] src;
    } lane_sel_t;

    function automatic logic [2:0] size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic is_misaligned(acc_size_e s, logic [1:0] lo);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo;
            default: return 1'b1;
        endcase
    endfunction

    // Byte index within the word value that belongs at offset k from the base.
    function automatic logic [1:0] lane_src(acc_size_e s, logic [1:0] k, logic big);
        logic [2:0] n;
        logic [2:0] rev;
        n   = size_bytes(s);
        rev = n - 3'd1 - {1'b0, k};
        return big ? rev[1:0] : k;
    endfunction

endpackage

// File: rtl/emem_access_decode.sv
module emem_access_decode
    import emem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  acc_size_e                   size,
    input  logic                        big_endian,
    output logic                        misalign,
    output lane_sel_t [LANES-1:0]       sel
);

    logic [2:0]       nbytes;
    logic [LANES-1:0] act_vec;

    assign misalign = is_misaligned(size, addr[1:0]);
    assign nbytes   = size_bytes(size);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign sel[k].active = !misalign && (3'(k) < nbytes);
        assign sel[k].src    = lane_src(size, 2'(k), big_endian);
        assign act_vec[k]    = sel[k].active;
    end

    // R5: a legal single-byte access drives exactly one lane, mapped to byte 0
    a_r5_single_lane: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_BYTE) |-> ($countones(act_vec) == 1 && sel[0].active && sel[0].src == 2'd0));

    // R4: a legal halfword access touches two lanes carrying distinct bytes
    a_r4_half_lanes: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_HALF && !misalign) |-> ($countones(act_vec) == 2 && sel[0].src != sel[1].src));

endmodule

// File: rtl/emem_lane_xbar.sv
module emem_lane_xbar
    import emem_pkg::*;
(
    input  lane_sel_t [LANES-1:0]              sel,
    input  logic [WORD_W-1:0]                  wdata,
    input  logic [LANES-1:0][LANE_W-1:0]       lane_rd,
    output logic [LANES-1:0][LANE_W-1:0]       lane_wr,
    output logic [WORD_W-1:0]                  rdata
);

    for (genvar k = 0; k < LANES; k++) begin : g_wr
        assign lane_wr[k] = wdata[{sel[k].src, 3'b000} +: LANE_W];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel[k].active) begin
                rdata[{sel[k].src, 3'b000} +: LANE_W] = lane_rd[k];
            end
        end
    end

endmodule

// File: rtl/emem_byte_store.sv
module emem_byte_store
    import emem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [ADDR_W-1:0]                  base,
    input  logic [LANES-1:0]                   lane_we,
    input  logic [LANES-1:0][LANE_W-1:0]       lane_wdata,
    output logic [LANES-1:0][LANE_W-1:0]       lane_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][LANE_W-1:0]  mem;
    logic [LANES-1:0][ADDR_W-1:0]  lane_addr;

    for (genvar k = 0; k < LANES; k++) begin : g_port
        assign lane_addr[k]  = base + ADDR_W'(k);
        assign lane_rdata[k] = mem[lane_addr[k]];

        // R9: an enabled lane's byte is present at its address after the edge
        a_r9_lane_commit: assert property (@(posedge clk) disable iff (rst)
            lane_we[k] |=> (mem[$past(lane_addr[k])] == $past(lane_wdata[k])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_we[k]) begin
                    mem[lane_addr[k]] <= lane_wdata[k];
                end
            end
        end
    end

    // R8: with no lane writing, no stored byte moves (mode changes included)
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (lane_we == '0) |=> $stable(mem));

endmodule

// File: rtl/emem_port.sv
module emem_port
    import emem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              big_endian,
    output logic [31:0]       rdata,
    output logic              misalign
);

    acc_size_e                     size_q;
    lane_sel_t [LANES-1:0]         sel;
    logic [LANES-1:0]              lane_we;
    logic [LANES-1:0][LANE_W-1:0]  lane_wr;
    logic [LANES-1:0][LANE_W-1:0]  lane_rd;

    assign size_q = acc_size_e'(size);

    emem_access_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .size       (size_q),
        .big_endian (big_endian),
        .misalign   (misalign),
        .sel        (sel)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_we
        assign lane_we[k] = wr_en && sel[k].active;
    end

    emem_lane_xbar u_xbar (
        .sel     (sel),
        .wdata   (wdata),
        .lane_rd (lane_rd),
        .lane_wr (lane_wr),
        .rdata   (rdata)
    );

    emem_byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .base       (addr),
        .lane_we    (lane_we),
        .lane_wdata (lane_wr),
        .lane_rdata (lane_rd)
    );

    // R7: a flagged access enables no lane and returns zero
    a_r7_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (lane_we == '0 && rdata == '0));

    // R6: single-byte loads are zero-extended
    a_r6_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (size_q == SZ_BYTE) |-> (rdata[31:8] == '0));

    // R6: halfword loads are zero-extended
    a_r6_half_zext: assert property (@(posedge clk) disable iff (rst)
        (size_q == SZ_HALF) |-> (rdata[31:16] == '0));

    // R9: a load-only cycle writes nothing
    a_r9_no_write_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (lane_we == '0));

endmodule

// File: tb/tb_emem_port.sv
`timescale 1ns/1ps
module tb_emem_port;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic              wr_en;
    logic [31:0]       wdata;
    logic              big_endian;
    logic [31:0]       rdata;
    logic              misalign;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    emem_port #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .size(size), .wr_en(wr_en),
        .wdata(wdata), .big_endian(big_endian), .rdata(rdata), .misalign(misalign)
    );

    function automatic int nbytes(int sz);
        if (sz == 0) return 1;
        if (sz == 1) return 2;
        if (sz == 2) return 4;
        return 0;
    endfunction

    function automatic bit model_mis(int a, int sz);
        if (sz == 3) return 1;
        if (sz == 2) return (a % 4) != 0;
        if (sz == 1) return (a % 2) != 0;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(int a, int sz, bit be);
        logic [31:0] v = '0;
        int n = nbytes(sz);
        if (model_mis(a, sz)) return '0;
        for (int i = 0; i < n; i++) begin
            int pos = be ? (n - 1 - i) : i;
            v = v | (32'(ref_mem[(a + i) % DEPTH]) << (8 * pos));
        end
        return v;
    endfunction

    task automatic model_write(int a, int sz, logic [31:0] wd, bit be);
        int n = nbytes(sz);
        for (int i = 0; i < n; i++) begin
            int pos = be ? (n - 1 - i) : i;
            ref_mem[(a + i) % DEPTH] = wd[8*pos +: 8];
        end
    endtask

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock of traffic: drive at negedge, compare before the edge, update model at the edge.
    task automatic step(int a, int sz, bit we, logic [31:0] wd, bit be,
                        string tag, bit use_lit = 0, logic [31:0] lit = '0);
        logic [31:0] exp_r;
        bit          exp_m;
        @(negedge clk);
        addr = ADDR_W'(a); size = 2'(sz); wr_en = we; wdata = wd; big_endian = be;
        #1;
        exp_m = model_mis(a, sz);
        exp_r = model_read(a, sz, be);
        check(rdata == exp_r, tag, "rdata", rdata, exp_r);
        check(misalign == exp_m, tag, "misalign", 32'(misalign), 32'(exp_m));
        if (use_lit) check(rdata == lit, tag, "literal", rdata, lit);
        @(posedge clk);
        if (we && !exp_m) model_write(a, sz, wd, be);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        rst = 1'b1; addr = '0; size = 2'd2; wr_en = 1'b0; wdata = '0; big_endian = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: cleared after reset
        for (int a = 0; a < DEPTH; a += 4) step(a, 2, 0, '0, a[2], "R1", 1, 32'h0);

        // R3: big-endian word layout
        step(0, 2, 1, 32'h87654321, 1, "R3");
        step(0, 0, 0, '0, 1, "R3", 1, 32'h87);
        step(1, 0, 0, '0, 0, "R3", 1, 32'h65);
        step(2, 0, 0, '0, 1, "R3", 1, 32'h43);
        step(3, 0, 0, '0, 0, "R3", 1, 32'h21);
        // R8: mode flip does not move bytes
        step(0, 2, 0, '0, 1, "R8", 1, 32'h87654321);
        step(0, 2, 0, '0, 0, "R8", 1, 32'h21436587);

        // R2: little-endian word layout
        step(4, 2, 1, 32'h87654321, 0, "R2");
        step(4, 0, 0, '0, 0, "R2", 1, 32'h21);
        step(5, 0, 0, '0, 1, "R2", 1, 32'h43);
        step(6, 0, 0, '0, 0, "R2", 1, 32'h65);
        step(7, 0, 0, '0, 1, "R2", 1, 32'h87);
        step(4, 2, 0, '0, 1, "R8", 1, 32'h21436587);

        // R4: halfword stores in both orders
        step(8, 1, 1, 32'hFFFFBEEF, 0, "R4");
        step(8, 0, 0, '0, 0, "R4", 1, 32'hEF);
        step(9, 0, 0, '0, 0, "R4", 1, 32'hBE);
        step(8, 2, 0, '0, 0, "R4", 1, 32'h0000BEEF);
        step(12, 1, 1, 32'h1234CAFE, 1, "R4");
        step(12, 0, 0, '0, 0, "R4", 1, 32'hCA);
        step(13, 0, 0, '0, 0, "R4", 1, 32'hFE);
        step(12, 2, 0, '0, 0, "R4", 1, 32'h0000FECA);
        // R6: zero-extended halfword loads, both orders
        step(12, 1, 0, '0, 1, "R6", 1, 32'h0000CAFE);
        step(12, 1, 0, '0, 0, "R6", 1, 32'h0000FECA);

        // R5: byte stores ignore upper data and neighbours
        step(17, 0, 1, 32'hFFFFFF5A, 1, "R5");
        step(18, 0, 1, 32'hABCDEFA5, 0, "R5");
        step(16, 2, 0, '0, 0, "R5", 1, 32'h00A55A00);
        step(18, 0, 0, '0, 1, "R6", 1, 32'h000000A5);

        // R7: misaligned and reserved accesses write nothing, return zero
        step(20, 2, 1, 32'h11111111, 0, "R7");
        step(21, 2, 1, 32'hDEADBEEF, 0, "R7", 1, 32'h0);
        step(23, 1, 1, 32'hDEADBEEF, 1, "R7", 1, 32'h0);
        step(20, 3, 1, 32'hDEADBEEF, 0, "R7", 1, 32'h0);
        step(20, 2, 0, '0, 0, "R7", 1, 32'h11111111);

        // R9: same-cycle load sees old bytes, new ones after the edge
        step(24, 2, 1, 32'h11223344, 0, "R9", 1, 32'h0);
        step(24, 2, 0, '0, 0, "R9", 1, 32'h11223344);
        step(24, 2, 0, 32'hFFFFFFFF, 1, "R9", 1, 32'h44332211);
        step(24, 2, 0, '0, 0, "R9", 1, 32'h11223344);

        // Mixed traffic against the model (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 3000; i++) begin
            int a  = int'($urandom_range(0, DEPTH - 1));
            int sz = int'($urandom_range(0, 3));
            bit we = bit'($urandom_range(0, 1));
            bit be = bit'($urandom_range(0, 1));
            if ($urandom_range(0, 3) != 0) begin
                if (sz == 2) a = a & ~3;
                if (sz == 1) a = a & ~1;
            end
            step(a, sz, we, $urandom, be, "R2_R3_R4_R5_R7");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule